// File: doc/BRIEF.md
# Clock-Generator Configuration Slave

This block is a two-wire serial slave that holds the configuration bytes of a clock generator and presents them as parallel control outputs. A host writes it with block transfers. The slave acknowledges a leading command byte and a leading count byte and then throws both away. The data that follows always lands in register byte 0 first and then in ascending order. The host may end the transfer after any whole byte.

A block read returns a count of seven first. It then returns every register byte in order, ending with a fixed identification byte.

Several bits are not ordinary storage:
- A three-bit frequency-select field and a multiplier-select flag are captured from strap pins on the first low level of the power-good strobe after reset.
- Two bits of byte 0 show the live levels of the two stop pins.

The serial lines are oversampled by the system clock through synchronisers. SDA is driven through an open-drain enable. Clock stretching, arbitration and 10-bit addressing are not supported.

Top module: `clkcfg_serial_slave`

## Requirements
- R1: The slave pulls SDA low in the acknowledge slot of the address byte only for 0xD2 (write) and 0xD3 (read). For any other address it leaves SDA released and ignores the bus until the next start condition.
- R2: In a write, the two bytes after the address are acknowledged and discarded. The next data byte is stored in byte 0, and each later byte goes to the next higher byte index.
- R3: A write that stops after N whole data bytes changes only bytes 0..N-1. All other bytes keep their values.
- R4: Data bytes beyond byte 5 in a write are acknowledged and dropped. No stored byte changes because of them.
- R5: A read returns 0x07 first, then bytes 0 through 6 (MSB first), each sent only after the master has acknowledged the previous one. A master non-acknowledge ends the transfer and releases SDA.
- R6: Byte 6 is read-only and reads as 0xFF by default. It is made of a revision nibble in bits 7:4 and a vendor nibble in bits 3:0.
- R7: On the first low level of the power-good strobe after reset, the strap pins are captured. The frequency-select pins go into byte 0 bits 2:0 and the multiplier pin into byte 1 bit 7. Later strobe pulses have no effect. Byte 0 bits 2:0 can be overwritten by a write. Byte 1 bit 7 cannot.
- R8: Byte 0 bit 4 shows the live level of `stop_a_pin`, and byte 0 bit 3 the live level of `stop_b_pin`. Written values for these two bits are ignored.
- R9: After reset, bytes 1..5 read 0x07, 0x7F, 0xC7, 0x3F and 0x00. Byte 0 reads zero apart from the live bits until the straps are captured. `cfg_q` shows byte k at bits 8k+7:8k, for k from 0 to 5.
- R10: A stop condition (SDA rising while SCL is high) abandons a partly received byte without storing it. A start condition (SDA falling while SCL is high) always restarts the address phase, including a repeated start in the middle of a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | When high, SDA is pulled low |
| pwrgd_n | input | 1 | Power-good strobe; its first low level captures the straps |
| fsel_pins | input | 3 | Frequency-select strap pins |
| mult_pin | input | 1 | Multiplier-select strap pin |
| stop_a_pin | input | 1 | First stop pin, shown live in byte 0 bit 4 |
| stop_b_pin | input | 1 | Second stop pin, shown live in byte 0 bit 3 |
| cfg_q | output | 48 | Register bytes 0..5 as seen on a read |

## Verification
The assertions assume that every SCL and SDA level is held for several system clocks beyond the two-flop synchroniser. They also assume the master never creates a start or stop condition while the slave is pulling SDA low. The bench therefore holds each quarter of a bit period for eight clocks. It issues a stop only after a released acknowledge slot, or after its own non-acknowledge of a read. It holds the strap pins steady around the strobe edge. The address test sweeps every address byte except the read address, which gets a full read of its own.

// File: rtl/clkcfg_pkg.sv
// Shared constants and helpers for the clock-generator configuration slave.
// Assumes byte-wide registers; byte layout is fixed by the host software.
package clkcfg_pkg;
    localparam int BYTE_W     = 8;
    localparam int RW_BYTES   = 6;   // bytes 0..5 are stored
    localparam int ALL_BYTES  = 7;   // bytes 0..6 are readable
    localparam int SKIP_BYTES = 2;   // command and count bytes dropped on write
    localparam int IDX_W      = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_WDATA, ST_ACK, ST_TX, ST_RACK
    } tw_state_e;

    // Power-on value of each stored byte
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            1:       return 8'h07;
            2:       return 8'h7F;
            3:       return 8'hC7;
            4:       return 8'h3F;
            default: return 8'h00;
        endcase
    endfunction

    // Bits a host write may change in each stored byte
    function automatic logic [BYTE_W-1:0] wr_mask(input int idx);
        case (idx)
            0:       return 8'hE7;
            1:       return 8'h7F;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/tw_line_sync.sv
// Two-flop synchroniser for SCL and SDA plus edge and bus-condition detection.
// Assumes both lines are idle high and stay stable for several clk cycles.
module tw_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LINES = 2;  // index 0 = SCL, 1 = SDA

    logic [LINES-1:0] raw;
    logic [LINES-1:0] meta_q;
    logic [LINES-1:0] sync_q;
    logic [LINES-1:0] prev_q;

    assign raw = {sda_in, scl_in};

    // Synchronise each line and keep one cycle of history for edge detection
    for (genvar g = 0; g < LINES; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[g] <= 1'b1;
                sync_q[g] <= 1'b1;
                prev_q[g] <= 1'b1;
            end else begin
                meta_q[g] <= raw[g];
                sync_q[g] <= meta_q[g];
                prev_q[g] <= sync_q[g];
            end
        end
    end

    assign sda_s     = sync_q[1];
    assign scl_rise  = sync_q[0] & ~prev_q[0];
    assign scl_fall  = ~sync_q[0] & prev_q[0];
    assign start_det = sync_q[0] & prev_q[0] & prev_q[1] & ~sync_q[1];
    assign stop_det  = sync_q[0] & prev_q[0] & ~prev_q[1] & sync_q[1];
endmodule

// File: rtl/tw_byte_engine.sv
// Bit and byte protocol engine: address match, write byte stream with the
// two leading bytes skipped, and the read byte stream with master acknowledge.
// Assumes no clock stretching and a single master.
module tw_byte_engine
    import clkcfg_pkg::*;
#(
    parameter logic [6:0] ADDR7 = 7'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              sda_drv,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data,
    output logic [IDX_W-1:0]  tx_sel
);
    localparam logic [IDX_W-1:0] SKIP    = IDX_W'(SKIP_BYTES);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    tw_state_e         st;
    logic [2:0]        bit_cnt;
    logic              got;
    logic [BYTE_W-1:0] sh;
    logic              is_read;
    logic [IDX_W-1:0]  wr_cnt;
    logic [BYTE_W-1:0] txsh;
    logic              nack;

    // Protocol state machine, advanced on synchronised SCL edges
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            got     <= 1'b0;
            sh      <= '0;
            is_read <= 1'b0;
            wr_cnt  <= '0;
            txsh    <= '0;
            nack    <= 1'b0;
            sda_drv <= 1'b0;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
            tx_sel  <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_det) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                got     <= 1'b0;
                sda_drv <= 1'b0;
                wr_cnt  <= '0;
                tx_sel  <= '0;
            end else if (stop_det) begin
                st      <= ST_IDLE;
                got     <= 1'b0;
                sda_drv <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise && !got) begin
                            sh <= {sh[BYTE_W-2:0], sda_s};
                            if (bit_cnt == 3'd7) got <= 1'b1;
                            else                 bit_cnt <= bit_cnt + 3'd1;
                        end else if (scl_fall && got) begin
                            got     <= 1'b0;
                            bit_cnt <= '0;
                            if (st == ST_ADDR) begin
                                if (sh[7:1] == ADDR7) begin
                                    st      <= ST_ACK;
                                    sda_drv <= 1'b1;
                                    is_read <= sh[0];
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                st      <= ST_ACK;
                                sda_drv <= 1'b1;
                                if (wr_cnt >= SKIP) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= wr_cnt - SKIP;
                                    wr_data <= sh;
                                end
                                if (wr_cnt != IDX_MAX) wr_cnt <= wr_cnt + 1'b1;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                txsh    <= tx_byte;
                                sda_drv <= ~tx_byte[BYTE_W-1];
                                if (tx_sel != IDX_MAX) tx_sel <= tx_sel + 1'b1;
                                st      <= ST_TX;
                            end else begin
                                sda_drv <= 1'b0;
                                st      <= ST_WDATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                sda_drv <= 1'b0;
                                st      <= ST_RACK;
                            end else begin
                                bit_cnt <= bit_cnt + 3'd1;
                                txsh    <= {txsh[BYTE_W-2:0], 1'b0};
                                sda_drv <= ~txsh[BYTE_W-2];
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack <= sda_s;
                        end else if (scl_fall) begin
                            if (nack) begin
                                st <= ST_IDLE;
                            end else begin
                                bit_cnt <= '0;
                                txsh    <= tx_byte;
                                sda_drv <= ~tx_byte[BYTE_W-1];
                                if (tx_sel != IDX_MAX) tx_sel <= tx_sel + 1'b1;
                                st      <= ST_TX;
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R1 / R5: SDA is pulled only in an acknowledge slot or while sending data
    a_r1_drive_only_in_slots: assert property (@(posedge clk) disable iff (!rst_n)
        sda_drv |-> (st == ST_ACK || st == ST_TX));

    // R10: a stop condition leaves the bus released and the engine idle
    a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (st == ST_IDLE && !sda_drv));

    // R2: a store request only accompanies a write acknowledge
    a_r2_store_in_write_ack: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st == ST_ACK && !is_read));

    // R5: SDA is released while the master acknowledges a read byte
    a_r5_release_for_master_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RACK) |-> !sda_drv);
endmodule

// File: rtl/clkcfg_regfile.sv
// Configuration storage: six stored bytes, the strap capture, the live stop
// bits and the read-frame multiplexer (count, bytes 0..5, identification).
// Assumes strap pins are stable while the power-good strobe first goes low.
module clkcfg_regfile
    import clkcfg_pkg::*;
#(
    parameter logic [BYTE_W-1:0] ID_BYTE = 8'hFF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic [BYTE_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           tx_sel,
    input  logic                       pwrgd_n,
    input  logic [2:0]                 fsel_pins,
    input  logic                       mult_pin,
    input  logic                       stop_a_pin,
    input  logic                       stop_b_pin,
    output logic [BYTE_W-1:0]          tx_byte,
    output logic [RW_BYTES*BYTE_W-1:0] cfg_q
);
    localparam int FLAT_W = RW_BYTES * BYTE_W;

    logic [FLAT_W-1:0] stored_flat;
    logic [FLAT_W-1:0] view;
    logic              pg_meta, pg_sync;
    logic              strap_done;
    logic              strap_now;
    logic              mult_q;

    assign strap_now = !pg_sync && !strap_done;

    // Synchronise the power-good strobe and capture the straps once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pg_meta    <= 1'b1;
            pg_sync    <= 1'b1;
            strap_done <= 1'b0;
            mult_q     <= 1'b0;
        end else begin
            pg_meta <= pwrgd_n;
            pg_sync <= pg_meta;
            if (strap_now) begin
                strap_done <= 1'b1;
                mult_q     <= mult_pin;
            end
        end
    end

    for (genvar g = 0; g < RW_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] q;
        // Hold one byte: default on reset, straps into byte 0, masked writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= reg_default(g);
            end else begin
                if (g == 0 && strap_now) q[2:0] <= fsel_pins;
                if (wr_en && wr_idx == IDX_W'(g)) q <= wr_data & wr_mask(g);
            end
        end
        assign stored_flat[g*BYTE_W +: BYTE_W] = q;
    end

    // Build the host-visible image: live stop bits and the captured multiplier bit
    always_comb begin
        view           = stored_flat;
        view[4]        = stop_a_pin;
        view[3]        = stop_b_pin;
        view[BYTE_W+7] = mult_q;
    end

    assign cfg_q = view;

    // Select the byte for the current position in a read frame
    always_comb begin
        tx_byte = '1;
        if (tx_sel == '0) tx_byte = BYTE_W'(ALL_BYTES);
        for (int k = 0; k < RW_BYTES; k++) begin
            if (tx_sel == IDX_W'(k + 1)) tx_byte = view[k*BYTE_W +: BYTE_W];
        end
        if (tx_sel == IDX_W'(ALL_BYTES)) tx_byte = ID_BYTE;
    end

    // R7: strap capture happens at most once per reset
    a_r7_strap_once: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done |=> strap_done);

    // R7: the captured multiplier bit never changes afterwards
    a_r7_mult_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        strap_done |=> $stable(mult_q));

    // R4: a store beyond the last writable byte changes nothing
    a_r4_no_store_past_end: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(RW_BYTES) && strap_done) |=> $stable(stored_flat));

    // R3: without a store request the stored bytes hold
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && strap_done) |=> $stable(stored_flat));
endmodule

// File: rtl/clkcfg_serial_slave.sv
// Top level of the clock-generator configuration slave: line synchroniser,
// protocol engine and register file. Assumes an external pull-up on SDA.
module clkcfg_serial_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]        ADDR7   = 7'h69,
    parameter logic [BYTE_W-1:0] ID_BYTE = 8'hFF
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_in,
    input  logic                       sda_in,
    output logic                       sda_oe,
    input  logic                       pwrgd_n,
    input  logic [2:0]                 fsel_pins,
    input  logic                       mult_pin,
    input  logic                       stop_a_pin,
    input  logic                       stop_b_pin,
    output logic [RW_BYTES*BYTE_W-1:0] cfg_q
);
    logic              sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx, tx_sel;
    logic [BYTE_W-1:0] wr_data, tx_byte;

    tw_line_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tw_byte_engine #(.ADDR7(ADDR7)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .tx_byte   (tx_byte),
        .sda_drv   (sda_oe),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .tx_sel    (tx_sel)
    );

    clkcfg_regfile #(.ID_BYTE(ID_BYTE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .tx_sel     (tx_sel),
        .pwrgd_n    (pwrgd_n),
        .fsel_pins  (fsel_pins),
        .mult_pin   (mult_pin),
        .stop_a_pin (stop_a_pin),
        .stop_b_pin (stop_b_pin),
        .tx_byte    (tx_byte),
        .cfg_q      (cfg_q)
    );
endmodule

// File: tb/clkcfg_serial_slave_bench.sv
// Self-checking bench: drives the serial bus as a master and keeps its own
// model of the expected register bytes.
module clkcfg_serial_slave_bench;
    localparam int Q = 8;  // clk cycles per quarter bit

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1, sda_m = 1'b1;
    logic        pwrgd_n = 1'b1;
    logic [2:0]  fsel_pins = 3'b101;
    logic        mult_pin = 1'b1;
    logic        stop_a_pin = 1'b1, stop_b_pin = 1'b0;
    logic        sda_oe;
    logic [47:0] cfg_q;
    wire         sda_line = sda_m & ~sda_oe;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] exp_b [6];
    logic       exp_mult = 1'b0;

    always #2 clk = ~clk;

    clkcfg_serial_slave u_clkcfg_serial_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .pwrgd_n(pwrgd_n), .fsel_pins(fsel_pins), .mult_pin(mult_pin),
        .stop_a_pin(stop_a_pin), .stop_b_pin(stop_b_pin), .cfg_q(cfg_q));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] view_exp(input int k);
        case (k)
            0:       return {exp_b[0][7:5], stop_a_pin, stop_b_pin, exp_b[0][2:0]};
            1:       return {exp_mult, exp_b[1][6:0]};
            6:       return 8'hFF;
            default: return exp_b[k];
        endcase
    endfunction

    function automatic logic [7:0] mask_of(input int k);
        return (k == 0) ? 8'hE7 : (k == 1) ? 8'h7F : 8'hFF;
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        acked = ~sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q); scl_m = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_m = 1'b0;
        end
        sda_m = ~mack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic check_cfg(input string req);
        for (int k = 0; k < 6; k++) chk(req, cfg_q[k*8 +: 8], view_exp(k));
    endtask

    // Block write: address, skip bytes, n data bytes, stop; model follows R2/R4
    task automatic block_write(input logic [7:0] d [16], input int n, input string req);
        logic a;
        bus_start();
        send_byte(8'hD2, a); chk("R1 write address ack", {7'd0, a}, 8'd1);
        send_byte(8'h3C, a); chk("R2 command ack", {7'd0, a}, 8'd1);
        send_byte(8'hC3, a); chk("R2 count ack", {7'd0, a}, 8'd1);
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], a);
            chk(req, {7'd0, a}, 8'd1);
            if (k < 6) exp_b[k] = d[k] & mask_of(k);
        end
        bus_stop();
    endtask

    task automatic block_read(input string req);
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a); chk("R1 read address ack", {7'd0, a}, 8'd1);
        recv_byte(1'b1, b); chk("R5 count byte", b, 8'h07);
        for (int k = 0; k < 7; k++) begin
            recv_byte(k != 6, b);
            chk(k == 6 ? "R6 id byte" : req, b, view_exp(k));
        end
        chk("R5 bus released after nack", {7'd0, sda_oe}, 8'd0);
        bus_stop();
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        logic [7:0] d [16];
        for (int k = 0; k < 6; k++) exp_b[k] = (k == 1) ? 8'h07 : (k == 2) ? 8'h7F :
                                               (k == 3) ? 8'hC7 : (k == 4) ? 8'h3F : 8'h00;
        wq(5); rst_n = 1'b1; wq(5);
        check_cfg("R9 reset defaults");
        chk("R1 idle released", {7'd0, sda_oe}, 8'd0);

        // R7: strap capture on first strobe low, later pulses ignored
        pwrgd_n = 1'b0; wq(6);
        exp_b[0][2:0] = 3'b101; exp_mult = 1'b1;
        check_cfg("R7 strap capture");
        fsel_pins = 3'b010; mult_pin = 1'b0;
        pwrgd_n = 1'b1; wq(6); pwrgd_n = 1'b0; wq(6);
        check_cfg("R7 second strobe ignored");

        // R1: sweep all address bytes except the read address
        for (int ad = 0; ad < 256; ad++) begin
            if (ad == 8'hD3) continue;
            bus_start();
            send_byte(8'(ad), a);
            chk("R1 address match", {7'd0, a}, {7'd0, ad == 8'hD2});
            bus_stop();
        end
        check_cfg("R1 no change from address sweep");

        // R2: full write of bytes 0..5 with computed patterns
        for (int k = 0; k < 16; k++) d[k] = 8'(k * 53 + 8'h1B);
        block_write(d, 6, "R2 data ack");
        check_cfg("R2 write lands from byte 0");
        block_read("R5 read byte");

        // R3: early stop after two bytes
        d[0] = 8'hFF; d[1] = 8'h00;
        block_write(d, 2, "R3 data ack");
        check_cfg("R3 untouched bytes hold");

        // R4: overrun past byte 5
        for (int k = 0; k < 16; k++) d[k] = 8'(k * 29 + 8'h44);
        block_write(d, 9, "R4 overrun ack");
        check_cfg("R4 overrun dropped");
        block_read("R4 readback");

        // R8: live stop bits, writes to them ignored
        d[0] = 8'h18;
        block_write(d, 1, "R8 data ack");
        for (int c = 0; c < 4; c++) begin
            stop_a_pin = c[1]; stop_b_pin = c[0]; wq(2);
            chk("R8 live stop bits", cfg_q[7:0], view_exp(0));
        end
        stop_a_pin = 1'b0; stop_b_pin = 1'b1;
        block_read("R8 readback");

        // R10: stop in the middle of a data byte
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
        bus_stop();
        check_cfg("R10 partial byte dropped");

        // R10: repeated start after a write header turns into a read
        bus_start();
        send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h00, a);
        bus_start();
        send_byte(8'hD3, a); chk("R10 repeated start address ack", {7'd0, a}, 8'd1);
        recv_byte(1'b1, b); chk("R10 count after repeated start", b, 8'h07);
        recv_byte(1'b0, b); chk("R10 byte 0 after repeated start", b, view_exp(0));
        bus_stop();
        check_cfg("R10 state after repeated start");

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule